// File: doc/BRIEF.md
# Half-Duplex Ethernet Frame Transmitter

This block turns a frame held in a byte-wide dual-port buffer into a complete Ethernet frame on a 4-bit, one-nibble-per-clock transmit interface. A buffer controller pulses `start_i` with the base address of the selected buffer. The engine reads a 16-bit length from the first two bytes of that buffer, fetches that many payload bytes, and emits the frame: preamble and start delimiter, payload, zero padding up to the minimum data size, and the CRC-32 check sequence.

In half-duplex mode a collision report during the frame makes the engine send a fixed jam pattern and wait a random number of slot times before it resends the same frame. The wait uses truncated binary exponential backoff drawn from an LFSR. After the sixteenth collision the engine gives up. Each start ends in a single completion pulse. An abort flag rides on that pulse when the frame was abandoned, so the controller can release the buffer's status bit.

Top module: `eth_tx_engine`

## Requirements
- R1: Every transmission attempt begins with fifteen nibbles of 0x5 followed by one nibble of 0xD. This is seven 0x55 bytes and a 0xD5 delimiter, each byte sent low nibble first.
- R2: The frame length is read from buffer byte base+0 (low) and base+1 (high). Payload byte i is read from base+2+i. Each data byte is sent low nibble first.
- R3: When the length is below 60, zero bytes follow the payload until 60 data bytes have been sent. A length of 0 gives 60 zero bytes.
- R4: After the data, eight nibbles carry the complement of the reflected CRC-32 (polynomial 0x04C11DB7, preset all ones) over all data and pad bytes, least significant nibble first.
- R5: `tx_en_o` stays high without a gap from the first preamble nibble to the last check-sequence nibble, with one nibble per clock.
- R6: `done_o` is high for exactly one cycle, in the cycle after the last check-sequence nibble. `abort_o` is low on a frame that completed.
- R7: In half-duplex mode, `col_i` high during preamble, data or check sequence makes the next eight nibbles the jam nibble 0xA, with `tx_en_o` held high.
- R8: After a jam that is not the last allowed one, `tx_en_o` stays low for r*SLOT_CYC+1 cycles, where r lies in [0, 2^min(n,10)-1] and n is the number of collisions so far. The full frame is then sent again from the preamble.
- R9: The jam that follows the sixteenth collision is followed directly by the completion pulse with `abort_o` high, and no further attempt is made.
- R10: With `half_duplex_i` low, `col_i` has no effect on the transmitted frame.
- R11: `busy_o` is high from the cycle after an accepted start until the completion pulse. A `start_i` received while busy is ignored.
- R12: After reset, `tx_en_o`, `done_o`, `abort_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock, one nibble per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| base_addr_i | input | AW | Byte address of the selected buffer |
| half_duplex_i | input | 1 | Enables collision handling |
| col_i | input | 1 | Collision indication from the line |
| mem_rd_o | output | 1 | Buffer read enable |
| mem_addr_o | output | AW | Buffer byte address |
| mem_rdata_i | input | 8 | Read data, valid one cycle after `mem_rd_o` |
| txd_o | output | 4 | Transmit nibble |
| tx_en_o | output | 1 | Transmit enable |
| done_o | output | 1 | One-cycle completion pulse |
| abort_o | output | 1 | Frame abandoned, valid with `done_o` |
| busy_o | output | 1 | Engine is handling a frame |

## Verification
The properties assume that the buffer returns data exactly one cycle after a read enable. They also assume that `half_duplex_i` does not change while a frame is in flight, so a jam can always be traced to a collision seen in half-duplex mode. The stimulus changes the duplex setting and the buffer contents only while the engine is idle. It drives `col_i` only at chosen points or holds it for whole frames. It fires a second start only to test that a start during a frame is ignored. The backoff slot is shortened through its parameter, so sixteen attempts fit in the run while the random draw range stays unchanged.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;
  localparam int LEN_W = 16;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LEN0, ST_LEN1, ST_LEN2, ST_PRE,
    ST_DATA, ST_FCS, ST_JAM, ST_BACKOFF, ST_DONE
  } tx_state_e;

  // reflected CRC-32, one nibble, LSB first
  function automatic logic [31:0] crc32_nibble(input logic [31:0] c, input logic [3:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 4; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
  import eth_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_i,
  input  logic       upd_i,
  input  logic [3:0] nib_i,
  input  logic       shift_i,
  output logic [3:0] fcs_nib_o
);
  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '1;
    else if (init_i)  crc_q <= '1;
    else if (upd_i)   crc_q <= crc32_nibble(crc_q, nib_i);
    else if (shift_i) crc_q <= {4'hF, crc_q[31:4]};
  end

  assign fcs_nib_o = ~crc_q[3:0];
endmodule

// File: rtl/eth_tx_backoff.sv
module eth_tx_backoff #(
  parameter int SLOT_CYC = 128,
  parameter int BO_LIMIT = 10,
  parameter int ATT_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ATT_W-1:0] attempts_i,
  output logic             expired_o
);
  localparam int WAIT_W = BO_LIMIT + $clog2(SLOT_CYC) + 1;

  logic [15:0]         lfsr_q;
  logic [BO_LIMIT-1:0] mask;
  logic [WAIT_W-1:0]   wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= 16'hACE1;
    else         lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
  end

  // truncated exponent: bit i allowed when i < min(attempts, BO_LIMIT)
  for (genvar i = 0; i < BO_LIMIT; i++) begin : g_mask
    assign mask[i] = (32'(attempts_i) > 32'($unsigned(i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              wait_q <= '0;
    else if (load_i)          wait_q <= WAIT_W'(lfsr_q[BO_LIMIT-1:0] & mask) * WAIT_W'(SLOT_CYC);
    else if (wait_q != '0)    wait_q <= wait_q - 1'b1;
  end

  assign expired_o = (wait_q == '0);
endmodule

// File: rtl/eth_tx_engine.sv
module eth_tx_engine
  import eth_tx_pkg::*;
#(
  parameter int          AW          = 12,
  parameter int          MIN_DATA    = 60,
  parameter int          PRE_NIBBLES = 16,
  parameter int          JAM_NIBBLES = 8,
  parameter logic [3:0]  JAM_NIB     = 4'hA,
  parameter int          SLOT_CYC    = 128,
  parameter int          MAX_ATT     = 16,
  parameter int          BO_LIMIT    = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic          half_duplex_i,
  input  logic          col_i,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_rdata_i,
  output logic [3:0]    txd_o,
  output logic          tx_en_o,
  output logic          done_o,
  output logic          abort_o,
  output logic          busy_o
);
  localparam int CNT_W = $clog2(PRE_NIBBLES > JAM_NIBBLES ? PRE_NIBBLES : JAM_NIBBLES);
  localparam int ATT_W = $clog2(MAX_ATT + 1);
  localparam int FCS_NIBBLES = 8;

  tx_state_e        st_q;
  logic [AW-1:0]    base_q;
  logic [LEN_W-1:0] len_q, idx_q, next_idx, nbytes;
  logic             ph_q, abort_q;
  logic [7:0]       byte_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ATT_W-1:0] att_q;
  logic [3:0]       data_nib, fcs_nib;
  logic             tx_st, col_hit, bo_load, bo_expired, crc_init;

  assign next_idx = idx_q + 1'b1;
  assign nbytes   = (len_q < LEN_W'(MIN_DATA)) ? LEN_W'(MIN_DATA) : len_q;
  assign data_nib = ph_q ? byte_q[7:4] : byte_q[3:0];
  assign tx_st    = (st_q == ST_PRE) || (st_q == ST_DATA) || (st_q == ST_FCS);
  assign col_hit  = tx_st && half_duplex_i && col_i;
  assign bo_load  = (st_q == ST_JAM) && (cnt_q == CNT_W'(JAM_NIBBLES - 1)) && (att_q < ATT_W'(MAX_ATT));
  assign crc_init = (st_q == ST_LEN2) || ((st_q == ST_BACKOFF) && bo_expired);

  always_comb begin
    mem_rd_o   = 1'b0;
    mem_addr_o = base_q;
    unique case (st_q)
      ST_LEN0: mem_rd_o = 1'b1;
      ST_LEN1: begin mem_rd_o = 1'b1; mem_addr_o = base_q + AW'(1); end
      ST_PRE: begin
        mem_addr_o = base_q + AW'(2);
        mem_rd_o   = (cnt_q == CNT_W'(PRE_NIBBLES - 2)) && (len_q != '0);
      end
      ST_DATA: begin
        mem_addr_o = base_q + AW'(2) + AW'(next_idx);
        mem_rd_o   = !ph_q && (next_idx < len_q);
      end
      default: ;
    endcase
  end

  always_comb begin
    txd_o = 4'h0;
    unique case (st_q)
      ST_PRE:  txd_o = (cnt_q == CNT_W'(PRE_NIBBLES - 1)) ? 4'hD : 4'h5;
      ST_DATA: txd_o = data_nib;
      ST_FCS:  txd_o = fcs_nib;
      ST_JAM:  txd_o = JAM_NIB;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; base_q <= '0; len_q <= '0; idx_q <= '0; ph_q <= 1'b0;
      byte_q <= '0; cnt_q <= '0; att_q <= '0; abort_q <= 1'b0;
    end else if (col_hit) begin
      st_q  <= ST_JAM;
      cnt_q <= '0;
      att_q <= att_q + 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q <= ST_LEN0; base_q <= base_addr_i; att_q <= '0; abort_q <= 1'b0;
        end
        ST_LEN0: st_q <= ST_LEN1;
        ST_LEN1: begin len_q[7:0] <= mem_rdata_i; st_q <= ST_LEN2; end
        ST_LEN2: begin len_q[15:8] <= mem_rdata_i; st_q <= ST_PRE; cnt_q <= '0; end
        ST_PRE: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(PRE_NIBBLES - 1)) begin
            st_q   <= ST_DATA;
            idx_q  <= '0;
            ph_q   <= 1'b0;
            byte_q <= (len_q != '0) ? mem_rdata_i : 8'h00;
          end
        end
        ST_DATA: begin
          if (!ph_q) ph_q <= 1'b1;
          else if (idx_q == nbytes - 1'b1) begin
            st_q  <= ST_FCS;
            cnt_q <= '0;
          end else begin
            idx_q  <= next_idx;
            ph_q   <= 1'b0;
            byte_q <= (next_idx < len_q) ? mem_rdata_i : 8'h00;
          end
        end
        ST_FCS: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(FCS_NIBBLES - 1)) st_q <= ST_DONE;
        end
        ST_JAM: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(JAM_NIBBLES - 1)) begin
            if (att_q >= ATT_W'(MAX_ATT)) begin
              st_q <= ST_DONE; abort_q <= 1'b1;
            end else st_q <= ST_BACKOFF;
          end
        end
        ST_BACKOFF: if (bo_expired) begin st_q <= ST_PRE; cnt_q <= '0; end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  eth_tx_crc u_crc (
    .clk_i, .rst_ni,
    .init_i   (crc_init),
    .upd_i    (st_q == ST_DATA),
    .nib_i    (data_nib),
    .shift_i  (st_q == ST_FCS),
    .fcs_nib_o(fcs_nib)
  );

  eth_tx_backoff #(.SLOT_CYC(SLOT_CYC), .BO_LIMIT(BO_LIMIT), .ATT_W(ATT_W)) u_backoff (
    .clk_i, .rst_ni,
    .load_i    (bo_load),
    .attempts_i(att_q),
    .expired_o (bo_expired)
  );

  assign tx_en_o = tx_st || (st_q == ST_JAM);
  assign done_o  = (st_q == ST_DONE);
  assign abort_o = (st_q == ST_DONE) && abort_q;
  assign busy_o  = (st_q != ST_IDLE);
endmodule

// File: rtl/eth_tx_engine_chk.sv
module eth_tx_engine_chk
  import eth_tx_pkg::*;
#(
  parameter logic [3:0] JAM_NIB = 4'hA
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       half_duplex_i,
  input logic       col_i,
  input logic [3:0] txd_o,
  input logic       tx_en_o,
  input logic       done_o,
  input logic       abort_o,
  input logic       busy_o,
  input tx_state_e  st_q
);
  logic in_frame;
  assign in_frame = (st_q == ST_PRE) || (st_q == ST_DATA) || (st_q == ST_FCS);

  p_pre_first_nib_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> txd_o == 4'h5);

  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_jam_follows_col_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame && half_duplex_i && col_i) |=> (tx_en_o && txd_o == JAM_NIB));

  p_jam_needs_hd_col_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_JAM && $past(st_q) != ST_JAM) |-> $past(half_duplex_i && col_i));

  p_abort_on_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> done_o);

  p_quiet_when_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!tx_en_o && !done_o));
endmodule

bind eth_tx_engine eth_tx_engine_chk #(.JAM_NIB(JAM_NIB)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .half_duplex_i(half_duplex_i), .col_i(col_i),
  .txd_o(txd_o), .tx_en_o(tx_en_o), .done_o(done_o), .abort_o(abort_o),
  .busy_o(busy_o), .st_q(st_q)
);

// File: tb/eth_tx_engine_bench.sv
`timescale 1ns/1ps
module eth_tx_engine_bench;
  localparam int AW = 12;
  localparam logic [3:0] JAM = 4'hA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, hd = 1'b0, col = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic mem_rd, tx_en, done, abort_f, busy;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata = 8'h00;
  logic [3:0] txd;
  logic [7:0] mem [0:4095];

  always #5 clk = ~clk;

  eth_tx_engine #(.AW(AW), .SLOT_CYC(4)) u_eth_tx_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base_addr),
    .half_duplex_i(hd), .col_i(col), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .txd_o(txd), .tx_en_o(tx_en), .done_o(done),
    .abort_o(abort_f), .busy_o(busy)
  );

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  int n_chk = 0, n_fail = 0;
  logic [3:0] cur[$], last_b[$], prev_b[$], exp_q[$];
  int nbursts = 0, idle_cnt = 0, last_gap = 0;

  always @(negedge clk) begin
    if (rst_n && tx_en) begin
      if (cur.size() == 0) last_gap = idle_cnt;
      cur.push_back(txd);
      idle_cnt = 0;
    end else begin
      if (cur.size() != 0) begin
        prev_b = last_b; last_b = cur; cur = {}; nbursts++;
      end
      idle_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic load_frame(input int base, input int len, input int seed);
    mem[base % 4096] = len[7:0];
    mem[(base + 1) % 4096] = len[15:8];
    for (int i = 0; i < len; i++) mem[(base + 2 + i) % 4096] = 8'((i * 7 + seed) & 255);
  endtask

  task automatic build(input int base, input int len);
    logic [31:0] crc;
    logic [7:0] b;
    int n;
    exp_q = {};
    repeat (15) exp_q.push_back(4'h5);
    exp_q.push_back(4'hD);
    crc = 32'hFFFFFFFF;
    n = (len < 60) ? 60 : len;
    for (int i = 0; i < n; i++) begin
      b = (i < len) ? mem[(base + 2 + i) % 4096] : 8'h00;
      exp_q.push_back(b[3:0]);
      exp_q.push_back(b[7:4]);
      for (int j = 0; j < 8; j++) begin
        if (crc[0] ^ b[j]) crc = (crc >> 1) ^ 32'hEDB88320;
        else               crc = crc >> 1;
      end
    end
    crc = ~crc;
    for (int i = 0; i < 8; i++) exp_q.push_back(crc[4*i +: 4]);
  endtask

  // compare q[lo..hi) against exp_q at same index; return first bad index or -1
  function automatic int diff_at(ref logic [3:0] q[$], input int lo, input int hi);
    for (int i = lo; i < hi; i++)
      if (i >= q.size() || i >= exp_q.size() || q[i] !== exp_q[i]) return i;
    return -1;
  endfunction

  task automatic cmp_frame(input string data_req);
    int d, ne, na, bad;
    ne = exp_q.size(); na = last_b.size();
    d = diff_at(last_b, 0, 16);
    chk(d < 0, "R1", "preamble nibble index", d, -1);
    d = diff_at(last_b, 16, ne - 8);
    chk(d < 0, data_req, "data nibble index", d, -1);
    bad = -1;
    if (na < 8) bad = 99;
    else for (int i = 0; i < 8; i++)
      if (last_b[na - 8 + i] !== exp_q[ne - 8 + i] && bad < 0) bad = i;
    chk(bad < 0, "R4", "fcs nibble index", bad, -1);
    chk(na == ne, "R5", "burst length", na, ne);
  endtask

  task automatic start_frame(input int base);
    @(negedge clk);
    base_addr = AW'(base);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ab);
    do @(negedge clk); while (!done);
    ab = abort_f;
    @(negedge clk);
    chk(!done, "R6", "done width beyond one cycle", int'(done), 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!tx_en && !done && !abort_f && !busy, "R12", "outputs in reset",
        int'({tx_en, done, abort_f, busy}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!tx_en && !busy, "R12", "outputs after reset", int'({tx_en, busy}), 0);
  endtask

  task automatic t_frame(input int base, input int len, input int seed, input string req);
    bit ab;
    int nb;
    load_frame(base, len, seed);
    build(base, len);
    nb = nbursts;
    start_frame(base);
    wait_done(ab);
    cmp_frame(req);
    chk(!ab, "R6", "abort on good frame", int'(ab), 0);
    chk(nbursts == nb + 1, "R5", "bursts per frame", nbursts - nb, 1);
  endtask

  task automatic t_busy_ignore();
    bit ab;
    int nb;
    load_frame(0, 30, 3);
    load_frame(12'h800, 70, 9);
    build(0, 30);
    nb = nbursts;
    start_frame(0);
    repeat (20) @(negedge clk);
    chk(busy, "R11", "busy during frame", int'(busy), 1);
    start_frame(12'h800);
    wait_done(ab);
    cmp_frame("R11");
    repeat (20) @(negedge clk);
    chk(nbursts == nb + 1, "R11", "bursts after ignored start", nbursts - nb, 1);
    chk(!busy, "R11", "busy after done", int'(busy), 0);
  endtask

  task automatic t_full_duplex();
    hd = 1'b0; col = 1'b1;
    t_frame(0, 25, 5, "R10");
    col = 1'b0;
  endtask

  task automatic t_collision();
    bit ab;
    int d, ps, nb;
    hd = 1'b1;
    load_frame(0, 20, 11);
    build(0, 20);
    nb = nbursts;
    start_frame(0);
    do @(negedge clk); while (cur.size() < 40);
    col = 1'b1;
    @(negedge clk);
    col = 1'b0;
    wait_done(ab);
    chk(nbursts == nb + 2, "R8", "bursts with one retry", nbursts - nb, 2);
    ps = prev_b.size();
    d = -1;
    for (int i = 0; i < 8; i++) if (ps < 8 || prev_b[ps - 8 + i] !== JAM) d = i;
    chk(d < 0, "R7", "jam nibble index", d, -1);
    d = diff_at(prev_b, 0, ps - 8);
    chk(d < 0 && ps > 24, "R7", "collided prefix index", d, -1);
    cmp_frame("R8");
    chk(last_gap == 1 || last_gap == 5, "R8", "backoff idle cycles", last_gap, 1);
    chk(!ab, "R8", "abort after retry success", int'(ab), 0);
    hd = 1'b0;
  endtask

  task automatic t_abort();
    bit ab;
    int nb;
    hd = 1'b1; col = 1'b1;
    load_frame(0, 10, 2);
    nb = nbursts;
    start_frame(0);
    wait_done(ab);
    chk(ab, "R9", "abort after 16 collisions", int'(ab), 1);
    chk(nbursts == nb + 16, "R9", "attempt count", nbursts - nb, 16);
    chk(last_b.size() == 9 && last_b[8] == JAM, "R9", "last attempt length", last_b.size(), 9);
    col = 1'b0; hd = 1'b0;
  endtask

  initial begin
    t_reset();
    t_frame(0, 10, 1, "R3");
    t_frame(0, 60, 4, "R2");
    t_frame(0, 100, 6, "R2");
    t_frame(12'h800, 45, 8, "R2");
    t_frame(0, 0, 0, "R3");
    t_busy_ignore();
    t_full_duplex();
    t_collision();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R6: actual no completion expected completion within 190000 cycles");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule